// File: doc/BRIEF.md
# Shadow-Buffered Clock Register Bank

This block sits between a serial access engine and a free-running time/calendar counter. When the chip-enable window opens, it copies the counter's seven time bytes into a user buffer. Every read in that window is answered from the buffer, so the counter can roll over mid-access without the host seeing a torn value. Host writes land in the same buffer. They reach the counter only when the window closes, as one load strobe that carries a per-byte mask.

The bank also holds two non-time registers. The protect register has one live bit, the top bit, and while it is set every write except to that register is refused. The charger-setup byte can be written only one byte at a time. Burst writes cover the seven time bytes plus the protect register. They commit only when all eight were written, and they are dropped entirely while protection is on.

A three-state sequencer drives the bank: `ST_IDLE`, `ST_ACTIVE` and `ST_COMMIT`.

| Transition | From | To | Condition and action |
|---|---|---|---|
| open | `ST_IDLE` | `ST_ACTIVE` | Chip enable is sampled high. The snapshot is taken. |
| close | `ST_ACTIVE` | `ST_COMMIT` | Chip enable is sampled low. The commit is issued. |
| rest | `ST_COMMIT` | `ST_IDLE` | Always, after one cycle. |

Top module: `clkbank_top`

## Requirements
- R1: After reset:
  - `load_strobe`, `presc_clr` and `ram_wr_ok` are 0.
  - The protect bit is 1.
  - The charger byte is 0x5C.
  - `acc_rdata` is 0 while no window is open.
- R2: On the first clock edge that samples `ce` high from idle, `live_time` is captured. Reads in that window return the captured bytes even if `live_time` changes later.
- R3: The read map inside a window is as follows:
  - Index i in 0..6 returns time byte i, taken from `live_time[8i+7:8i]`.
  - Address 7 returns {protect, 7'b0}.
  - Address 8 returns the charger byte.
  - Addresses 9..31 return 0.
  - Outside a window, reads return 0.
- R4: On the first edge that samples `ce` low in `ST_ACTIVE`, `load_strobe` rises for exactly one cycle if any time byte is to be committed. `load_mask` bit i marks the committed bytes, and `load_data` carries their buffered values.
- R5: A window with no accepted time-byte write produces no `load_strobe`.
- R6: `presc_clr` pulses together with `load_strobe` when, and only when, time byte 0 (seconds) is committed.
- R7: While the protect bit is 1, the following hold:
  - Single-byte writes to addresses 0..6 and 8 are ignored.
  - `ram_wr_ok` is 0.
  - Address 7 stays writable, so protection can be cleared.
- R8: A burst write (`acc_burst`=1) of all eight indices 0..7, with protection off, commits all seven time bytes (mask 0x7F) and the protect bit when the window closes.
- R9: A burst that misses any of indices 0..7 commits nothing in that window, including single-byte writes made in the same window.
- R10: A burst write made while protection is on commits nothing, not even the protect register.
- R11: Writes to addresses 9..31 are ignored, and a burst write to address 8 is ignored.
- R12: Within a window, a read of an accepted written address returns the written value. For address 7 this is with bits 6:0 forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Access window enable, already synchronised |
| acc_valid | input | 1 | Byte access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_burst | input | 1 | Access belongs to a burst |
| acc_addr | input | 5 | Register address, or byte index in a burst |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte (combinational) |
| live_time | input | 56 | Running counter bytes, byte i at [8i+7:8i] |
| load_strobe | output | 1 | One-cycle counter load |
| load_mask | output | 7 | Bytes to load |
| load_data | output | 56 | Load values |
| presc_clr | output | 1 | Prescaler reset, paired with a seconds load |
| ram_wr_ok | output | 1 | Scratch memory writes permitted |

## Verification
The bound checker watches four things on every cycle:
- the one-cycle shape of the load strobe and that it follows a sampled low on chip enable;
- the pairing of the prescaler reset with a seconds load;
- that no load is issued while the protect bit was set;
- that buffered read data holds steady when no write intervenes, with high addresses reading zero.

The other behaviours only show in the bench's scenarios:
- snapshot immunity to a mid-window rollover;
- the 128-subset sweep of single-byte commits;
- partial and protected bursts leaving the counter untouched;
- the refused charger access in burst mode.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;
    localparam int DW = 8;
    localparam int AW = 5;
    localparam int NT = 7;
    localparam logic [7:0] TRKL_RST = 8'h5C;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_COMMIT = 2'd2
    } bank_st_t;
endpackage

// File: rtl/clkbank_seq.sv
module clkbank_seq
    import clkbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    output logic snap,
    output logic win,
    output logic commit
);
    bank_st_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   st_d = ce ? ST_ACTIVE : ST_IDLE;
            ST_ACTIVE: st_d = ce ? ST_ACTIVE : ST_COMMIT;
            ST_COMMIT: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        snap   = (st_q == ST_IDLE)   &&  ce;
        win    = (st_q == ST_ACTIVE) &&  ce;
        commit = (st_q == ST_ACTIVE) && !ce;
    end
endmodule

// File: rtl/clkbank_wtrack.sv
module clkbank_wtrack #(
    parameter int AW = 5,
    parameter int NT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          snap,
    input  logic          win,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic          acc_burst,
    input  logic [AW-1:0] acc_addr,
    input  logic          wp,
    output logic          wr_en,
    output logic [NT+1:0] cmask
);
    localparam int NB = NT + 1;
    localparam int NR = NT + 2;
    localparam logic [AW-1:0] LIM_S  = AW'(NR);
    localparam logic [AW-1:0] LIM_B  = AW'(NB);
    localparam logic [AW-1:0] CTRL_A = AW'(NT);

    logic [NR-1:0] dirty_q;
    logic [NB-1:0] bmask_q;
    logic          wr_req;

    always_comb begin
        wr_req = win && acc_valid && acc_write;
        if (acc_burst)
            wr_en = wr_req && (acc_addr < LIM_B) && !wp;
        else
            wr_en = wr_req && (acc_addr < LIM_S) && (!wp || acc_addr == CTRL_A);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= '0;
            bmask_q <= '0;
        end else if (snap) begin
            dirty_q <= '0;
            bmask_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NR; i++) begin
                if (acc_addr == AW'(i)) begin
                    if (acc_burst) begin
                        if (i < NB) bmask_q[i] <= 1'b1;
                    end else begin
                        dirty_q[i] <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        if (bmask_q == '0)
            cmask = dirty_q;
        else if (&bmask_q)
            cmask = {dirty_q[NR-1], {NB{1'b1}}};
        else
            cmask = '0;
    end
endmodule

// File: rtl/clkbank_shadow.sv
module clkbank_shadow #(
    parameter int           DW        = 8,
    parameter int           AW        = 5,
    parameter int           NT        = 7,
    parameter logic [DW-1:0] TRKL_INIT = 8'h5C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snap,
    input  logic             win,
    input  logic             wr_en,
    input  logic [AW-1:0]    acc_addr,
    input  logic [DW-1:0]    wdata,
    input  logic             commit_wp,
    input  logic             commit_trkl,
    input  logic [NT*DW-1:0] live,
    output logic [DW-1:0]    rdata,
    output logic [NT*DW-1:0] buf_flat,
    output logic             wp,
    output logic [DW-1:0]    trkl
);
    localparam logic [AW-1:0] CTRL_A = AW'(NT);
    localparam logic [AW-1:0] TRKL_A = AW'(NT + 1);

    logic [DW-1:0] tb [NT];
    logic          wp_b;
    logic [DW-1:0] tr_b;

    for (genvar g = 0; g < NT; g++) begin : g_tbyte
        always_ff @(posedge clk) begin
            if (!rst_n)                              tb[g] <= '0;
            else if (snap)                           tb[g] <= live[g*DW +: DW];
            else if (wr_en && acc_addr == AW'(g))    tb[g] <= wdata;
        end
        assign buf_flat[g*DW +: DW] = tb[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_b <= 1'b1;
            tr_b <= TRKL_INIT;
        end else if (snap) begin
            wp_b <= wp;
            tr_b <= trkl;
        end else if (wr_en) begin
            if (acc_addr == CTRL_A) wp_b <= wdata[DW-1];
            if (acc_addr == TRKL_A) tr_b <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp   <= 1'b1;
            trkl <= TRKL_INIT;
        end else begin
            if (commit_wp)   wp   <= wp_b;
            if (commit_trkl) trkl <= tr_b;
        end
    end

    always_comb begin
        rdata = '0;
        if (win) begin
            for (int i = 0; i < NT; i++)
                if (acc_addr == AW'(i)) rdata = tb[i];
            if (acc_addr == CTRL_A) rdata = {wp_b, {(DW-1){1'b0}}};
            if (acc_addr == TRKL_A) rdata = tr_b;
        end
    end
endmodule

// File: rtl/clkbank_top.sv
module clkbank_top #(
    parameter int            DW        = clkbank_pkg::DW,
    parameter int            AW        = clkbank_pkg::AW,
    parameter int            NT        = clkbank_pkg::NT,
    parameter logic [DW-1:0] TRKL_INIT = clkbank_pkg::TRKL_RST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic             acc_burst,
    input  logic [AW-1:0]    acc_addr,
    input  logic [DW-1:0]    acc_wdata,
    output logic [DW-1:0]    acc_rdata,
    input  logic [NT*DW-1:0] live_time,
    output logic             load_strobe,
    output logic [NT-1:0]    load_mask,
    output logic [NT*DW-1:0] load_data,
    output logic             presc_clr,
    output logic             ram_wr_ok
);
    logic             snap, win, commit, wr_en, wp;
    logic [NT+1:0]    cmask;
    logic [NT*DW-1:0] buf_flat;
    logic [DW-1:0]    trkl;

    clkbank_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce     (ce),
        .snap   (snap),
        .win    (win),
        .commit (commit)
    );

    clkbank_wtrack #(.AW(AW), .NT(NT)) u_wtrack (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap      (snap),
        .win       (win),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_burst (acc_burst),
        .acc_addr  (acc_addr),
        .wp        (wp),
        .wr_en     (wr_en),
        .cmask     (cmask)
    );

    clkbank_shadow #(.DW(DW), .AW(AW), .NT(NT), .TRKL_INIT(TRKL_INIT)) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .snap        (snap),
        .win         (win),
        .wr_en       (wr_en),
        .acc_addr    (acc_addr),
        .wdata       (acc_wdata),
        .commit_wp   (commit && cmask[NT]),
        .commit_trkl (commit && cmask[NT+1]),
        .live        (live_time),
        .rdata       (acc_rdata),
        .buf_flat    (buf_flat),
        .wp          (wp),
        .trkl        (trkl)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_strobe <= 1'b0;
            load_mask   <= '0;
            load_data   <= '0;
            presc_clr   <= 1'b0;
        end else begin
            load_strobe <= commit && (|cmask[NT-1:0]);
            load_mask   <= commit ? cmask[NT-1:0] : '0;
            presc_clr   <= commit && cmask[0];
            if (commit) load_data <= buf_flat;
        end
    end

    assign ram_wr_ok = ~wp;

    logic unused_trkl;
    assign unused_trkl = ^trkl;
endmodule

// File: rtl/clkbank_chk.sv
module clkbank_chk #(
    parameter int AW = 5,
    parameter int DW = 8,
    parameter int NT = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce,
    input logic          win,
    input logic          acc_valid,
    input logic          acc_write,
    input logic [AW-1:0] acc_addr,
    input logic [DW-1:0] acc_rdata,
    input logic          load_strobe,
    input logic [NT-1:0] load_mask,
    input logic          presc_clr,
    input logic          ram_wr_ok
);
    localparam logic [AW-1:0] HI_A = AW'(NT + 2);

    // R4
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |=> !load_strobe);

    // R4
    commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |-> (!$past(ce) && load_mask != '0));

    // R6
    presc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        presc_clr |-> (load_strobe && load_mask[0]));

    // R7
    wp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |-> $past(ram_wr_ok));

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win && $past(win) && $stable(acc_addr) && !$past(acc_valid && acc_write))
        |-> $stable(acc_rdata));

    // R3
    hi_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr >= HI_A) |-> (acc_rdata == '0));
endmodule

bind clkbank_top clkbank_chk #(.AW(AW), .DW(DW), .NT(NT)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce          (ce),
    .win         (win),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_addr    (acc_addr),
    .acc_rdata   (acc_rdata),
    .load_strobe (load_strobe),
    .load_mask   (load_mask),
    .presc_clr   (presc_clr),
    .ram_wr_ok   (ram_wr_ok)
);

// File: tb/clkbank_top_tb_top.sv
`timescale 1ns/1ps
module clkbank_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_burst = 1'b0;
    logic [4:0]  acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  acc_rdata;
    logic [55:0] live_t = '0;
    logic        load_strobe;
    logic [6:0]  load_mask;
    logic [55:0] load_data;
    logic        presc_clr;
    logic        ram_wr_ok;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    clkbank_top dut_i (
        .clk(clk), .rst_n(rst_n), .ce(ce),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_burst(acc_burst),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .live_time(live_t), .load_strobe(load_strobe), .load_mask(load_mask),
        .load_data(load_data), .presc_clr(presc_clr), .ram_wr_ok(ram_wr_ok)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic open_win();
        ce = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input bit burst, input logic [4:0] a, input logic [7:0] d);
        acc_valid = 1'b1; acc_write = 1'b1; acc_burst = burst;
        acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_burst = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [7:0] e, input string tag);
        acc_addr = a;
        #1;
        chk(acc_rdata == e, tag, acc_rdata, e);
    endtask

    task automatic close_win(input logic [6:0] em, input logic [55:0] ed, input string tag);
        ce = 1'b0;
        @(negedge clk);
        chk(load_strobe == (em != 0), {tag, " R4 strobe"}, load_strobe, em != 0);
        chk(load_mask == em, {tag, " R4 mask"}, load_mask, em);
        for (int i = 0; i < 7; i++)
            if (em[i]) chk(load_data[i*8 +: 8] == ed[i*8 +: 8], {tag, " R4 data"},
                           load_data[i*8 +: 8], ed[i*8 +: 8]);
        chk(presc_clr == em[0], {tag, " R6 presc"}, presc_clr, em[0]);
        if (load_strobe)
            for (int i = 0; i < 7; i++)
                if (load_mask[i]) live_t[i*8 +: 8] = load_data[i*8 +: 8];
        @(negedge clk);
        chk(load_strobe == 1'b0, {tag, " R4 one-cycle"}, load_strobe, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [55:0] ed;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(load_strobe == 0, "R1 strobe", load_strobe, 0);
        chk(presc_clr == 0, "R1 presc", presc_clr, 0);
        chk(ram_wr_ok == 0, "R1 ram_wr_ok", ram_wr_ok, 0);
        rd_chk(5'd0, 8'h00, "R1 closed read");
        live_t = 56'h06_05_04_03_02_01_00;
        open_win();
        rd_chk(5'd7, 8'h80, "R1 protect");
        rd_chk(5'd8, 8'h5C, "R1 charger");
        // R7 protected writes
        wr(0, 5'd0, 8'h11);
        rd_chk(5'd0, 8'h00, "R7 blocked sec");
        wr(0, 5'd8, 8'h12);
        rd_chk(5'd8, 8'h5C, "R7 blocked charger");
        wr(0, 5'd7, 8'h00);
        rd_chk(5'd7, 8'h00, "R7 protect writable");
        close_win(7'h00, '0, "R7 none");
        chk(ram_wr_ok == 1, "R7 cleared", ram_wr_ok, 1);

        // R3 / R11 map and high addresses
        open_win();
        rd_chk(5'd8, 8'h5C, "R3 charger kept");
        rd_chk(5'd15, 8'h00, "R3 high addr");
        wr(0, 5'd20, 8'hFF);
        rd_chk(5'd20, 8'h00, "R11 high write");
        close_win(7'h00, '0, "R11 none");

        // R4 R5 R6 sweep of all time-byte subsets
        for (int m = 0; m < 128; m++) begin
            for (int i = 0; i < 7; i++) live_t[i*8 +: 8] = 8'(i * 11 + m);
            open_win();
            rd_chk(5'd0, 8'(m), "R2 snap");
            ed = '0;
            for (int i = 0; i < 7; i++) begin
                ed[i*8 +: 8] = 8'(m * 5 + i * 29 + 1);
                if (m[i]) wr(0, 5'(i), ed[i*8 +: 8]);
            end
            close_win(7'(m), ed, "R5 sweep");
        end

        // R12 readback, R3 control bit masking
        open_win();
        wr(0, 5'd1, 8'h33);
        rd_chk(5'd1, 8'h33, "R12 readback");
        wr(0, 5'd7, 8'hFF);
        rd_chk(5'd7, 8'h80, "R3 ctrl mask");
        close_win(7'h02, 56'h33 << 8, "R12 commit");
        chk(ram_wr_ok == 0, "R7 set", ram_wr_ok, 0);
        open_win(); wr(0, 5'd7, 8'h00); close_win(7'h00, '0, "R7 clear");

        // R2 rollover during long read
        live_t = 56'h00_00_00_00_23_59_59;
        open_win();
        live_t = 56'h00_00_00_01_00_00_00;
        repeat (3) @(negedge clk);
        rd_chk(5'd0, 8'h59, "R2 sec held");
        rd_chk(5'd1, 8'h59, "R2 min held");
        @(negedge clk);
        rd_chk(5'd2, 8'h23, "R2 hour held");
        close_win(7'h00, '0, "R2 no load");
        open_win();
        rd_chk(5'd3, 8'h01, "R2 new snap");
        close_win(7'h00, '0, "R2 close");

        // R8 full burst
        open_win();
        ed = 56'h47_06_12_28_15_42_30;
        for (int i = 0; i < 7; i++) wr(1, 5'(i), ed[i*8 +: 8]);
        wr(1, 5'd7, 8'h00);
        close_win(7'h7F, ed, "R8 burst");
        chk(ram_wr_ok == 1, "R8 protect", ram_wr_ok, 1);

        // R9 partial burst, with a single write in the same window
        open_win();
        for (int i = 0; i < 6; i++) wr(1, 5'(i), 8'hEE);
        wr(0, 5'd1, 8'h44);
        close_win(7'h00, '0, "R9 partial");
        chk(live_t == 56'h47_06_12_28_15_42_30, "R9 counter kept", live_t, 56'h47_06_12_28_15_42_30);

        // R11 burst to charger refused; single write accepted
        open_win(); wr(1, 5'd8, 8'h77); close_win(7'h00, '0, "R11 burst charger");
        open_win();
        rd_chk(5'd8, 8'h5C, "R11 charger kept");
        wr(0, 5'd8, 8'hA5);
        close_win(7'h00, '0, "R11 single charger");
        open_win(); rd_chk(5'd8, 8'hA5, "R3 charger written"); close_win(7'h00, '0, "R3 close");

        // R10 burst under protection
        open_win(); wr(0, 5'd7, 8'h80); close_win(7'h00, '0, "R10 set");
        open_win();
        for (int i = 0; i < 7; i++) wr(1, 5'(i), 8'h11);
        wr(1, 5'd7, 8'h00);
        close_win(7'h00, '0, "R10 burst");
        chk(ram_wr_ok == 0, "R10 protect kept", ram_wr_ok, 0);
        open_win(); rd_chk(5'd7, 8'h80, "R10 ctrl read"); close_win(7'h00, '0, "R10 close");

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule